// File: doc/BRIEF.md
# Flash controller status word

This block holds the status word that software reads from an embedded flash controller. The rest of the controller sends it single-cycle event pulses:
- a rejected command or key;
- a program or erase aimed at a protected region;
- a verify failure once programming ends;
- single-bit (corrected) and multi-bit (uncorrected) ECC errors, reported separately for the low and high 64-bit halves of the 128-bit array data bus.

Each event latches a flag. The flag holds until its own clear condition occurs.

The block also shows a live ready bit, taken from the controller's busy signal, and raises an interrupt when the controller is ready and the ready interrupt is enabled. The enable lives in the mode register elsewhere.

Reads are combinational: the word appears on the read data port in the cycle the read strobe is high. A read at the status address also schedules the clear-on-read flags to drop at the next clock edge. A new event pulse always wins over a clear that arrives in the same cycle, so no event is lost.

Top module: `fstat_reg`

## Requirements
- R1: Bit 0 of the status word is 1 when `busy_i` is 0 and 0 when `busy_i` is 1, in the same cycle, with no memory.
- R2: `irq_o` is 1 exactly when the ready bit is 1 and `rdy_irq_en_i` is 1.
- R3: Bit 1 (command error) is set by `cmd_err_evt_i`. It clears on a status read or on a command write (`cmd_wr_i`).
- R4: Bit 2 (lock error) is set by `lock_err_evt_i`. It clears on a status read or on a command write.
- R5: Bit 3 (flash error) is set by `verify_fail_evt_i`. It clears only on `prog_start_i`; status reads and command writes leave it unchanged.
- R6: For the low bus half (`ecc_*_evt_i[0]`), bit 16 records a single corrected ECC error and bit 17 a multi-bit uncorrected one. Both clear on a status read.
- R7: For the high bus half (`ecc_*_evt_i[1]`), bit 18 records a single corrected ECC error and bit 19 a multi-bit uncorrected one. Both clear on a status read.
- R8: Bits 4 to 15 and 20 to 31 of the status word are always 0.
- R9: An event pulse arriving in the same cycle as one of its flag's clear conditions leaves the flag set. A status read returns the flag values as they were before that read's clear.
- R10: After reset every sticky flag is 0, so with the controller idle the status word reads 0x00000001.
- R11: A status read is `rd_en_i` high with `rd_addr_i` equal to 0x08. `rd_data_o` is 0 outside a status read, and a read at any other address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W (8) | Register read address |
| rd_data_o | output | DATA_W (32) | Status word during a status read, else 0 |
| cmd_wr_i | input | 1 | Command register write pulse |
| prog_start_i | input | 1 | Programming operation start pulse |
| busy_i | input | 1 | Controller busy, live |
| rdy_irq_en_i | input | 1 | Ready interrupt enable from the mode register |
| cmd_err_evt_i | input | 1 | Invalid command or wrong key event |
| lock_err_evt_i | input | 1 | Protected region access event |
| verify_fail_evt_i | input | 1 | Erase or write verify failure event |
| ecc_single_evt_i | input | NUM_HALVES (2) | Corrected ECC error per bus half, bit 0 low half |
| ecc_multi_evt_i | input | NUM_HALVES (2) | Uncorrected ECC error per bus half, bit 0 low half |
| irq_o | output | 1 | Ready interrupt |

## Verification
The bound checker watches, on every cycle:
- the set and clear rules of each sticky flag, including the rule that an event beats a clear in the same cycle;
- that the flash error flag cannot move without its own event or a programming start;
- that the interrupt never fires while busy;
- that reserved bits and idle read data stay zero.

Other behaviour only the directed scenarios can show:
- which bit position each event lands in;
- that the word returned by a read is the value before its clear;
- that a read at a foreign address leaves flags intact;
- the exact reset word.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
   localparam int FLAG_RDY  = 0;
   localparam int FLAG_CMD  = 1;
   localparam int FLAG_LOCK = 2;
   localparam int FLAG_FERR = 3;
   localparam int ECC_BASE  = 16;
   localparam int ECC_KINDS = 2;   // 0: single corrected, 1: multi uncorrected

   function automatic int ecc_pos(input int half, input int kind);
      return ECC_BASE + ECC_KINDS * half + kind;
   endfunction
endpackage

// File: rtl/fstat_flag.sv
module fstat_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic d;

   generate
      if (SET_WINS) begin : g_set_wins
         assign d = set_i | (flag_o & ~clr_i);
      end else begin : g_clr_wins
         assign d = (set_i | flag_o) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o <= 1'b0;
      else         flag_o <= d;
   end
endmodule

// File: rtl/fstat_ecc_bank.sv
module fstat_ecc_bank #(
   parameter int NUM_HALVES = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  clr_i,
   input  logic [NUM_HALVES-1:0] single_evt_i,
   input  logic [NUM_HALVES-1:0] multi_evt_i,
   output logic [NUM_HALVES-1:0] single_q_o,
   output logic [NUM_HALVES-1:0] multi_q_o
);
   generate
      for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
         fstat_flag #(.SET_WINS(1'b1)) u_single (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (single_evt_i[h]),
            .clr_i  (clr_i),
            .flag_o (single_q_o[h])
         );
         fstat_flag #(.SET_WINS(1'b1)) u_multi (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (multi_evt_i[h]),
            .clr_i  (clr_i),
            .flag_o (multi_q_o[h])
         );
      end
   endgenerate
endmodule

// File: rtl/fstat_rdmux.sv
module fstat_rdmux
   import fstat_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_HALVES = 2
) (
   input  logic                  sel_i,
   input  logic                  rdy_i,
   input  logic                  cmd_i,
   input  logic                  lock_i,
   input  logic                  ferr_i,
   input  logic [NUM_HALVES-1:0] single_i,
   input  logic [NUM_HALVES-1:0] multi_i,
   output logic [DATA_W-1:0]     data_o
);
   logic [DATA_W-1:0] word;

   always_comb begin
      word            = '0;
      word[FLAG_RDY]  = rdy_i;
      word[FLAG_CMD]  = cmd_i;
      word[FLAG_LOCK] = lock_i;
      word[FLAG_FERR] = ferr_i;
      for (int h = 0; h < NUM_HALVES; h++) begin
         word[ecc_pos(h, 0)] = single_i[h];
         word[ecc_pos(h, 1)] = multi_i[h];
      end
   end

   assign data_o = sel_i ? word : '0;
endmodule

// File: rtl/fstat_reg.sv
module fstat_reg
   import fstat_pkg::*;
#(
   parameter int                 ADDR_W     = 8,
   parameter int                 DATA_W     = 32,
   parameter int                 NUM_HALVES = 2,
   parameter logic [ADDR_W-1:0]  STS_OFS    = 'h08,
   parameter bit                 IRQ_REG    = 1'b0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  rd_en_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   output logic [DATA_W-1:0]     rd_data_o,
   input  logic                  cmd_wr_i,
   input  logic                  prog_start_i,
   input  logic                  busy_i,
   input  logic                  rdy_irq_en_i,
   input  logic                  cmd_err_evt_i,
   input  logic                  lock_err_evt_i,
   input  logic                  verify_fail_evt_i,
   input  logic [NUM_HALVES-1:0] ecc_single_evt_i,
   input  logic [NUM_HALVES-1:0] ecc_multi_evt_i,
   output logic                  irq_o
);
   localparam int TOP_BIT = ECC_BASE + ECC_KINDS * NUM_HALVES - 1;

   generate
      if (NUM_HALVES < 1) begin : g_bad_halves
         $error("fstat_reg: NUM_HALVES must be at least 1");
      end
      if (TOP_BIT >= DATA_W) begin : g_bad_width
         $error("fstat_reg: DATA_W too narrow for the ECC flags");
      end
   endgenerate

   logic                  sts_rd;
   logic                  rdy;
   logic                  cmd_q;
   logic                  lock_q;
   logic                  ferr_q;
   logic [NUM_HALVES-1:0] ecc_s_q;
   logic [NUM_HALVES-1:0] ecc_m_q;
   logic                  cmd_clr;

   assign sts_rd  = rd_en_i && (rd_addr_i == STS_OFS);
   assign rdy     = ~busy_i;
   assign cmd_clr = sts_rd | cmd_wr_i;

   fstat_flag #(.SET_WINS(1'b1)) u_cmd (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (cmd_err_evt_i), .clr_i (cmd_clr), .flag_o (cmd_q)
   );

   fstat_flag #(.SET_WINS(1'b1)) u_lock (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (lock_err_evt_i), .clr_i (cmd_clr), .flag_o (lock_q)
   );

   fstat_flag #(.SET_WINS(1'b1)) u_ferr (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (verify_fail_evt_i), .clr_i (prog_start_i), .flag_o (ferr_q)
   );

   fstat_ecc_bank #(.NUM_HALVES(NUM_HALVES)) u_ecc (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (sts_rd),
      .single_evt_i (ecc_single_evt_i),
      .multi_evt_i  (ecc_multi_evt_i),
      .single_q_o   (ecc_s_q),
      .multi_q_o    (ecc_m_q)
   );

   fstat_rdmux #(.DATA_W(DATA_W), .NUM_HALVES(NUM_HALVES)) u_mux (
      .sel_i    (sts_rd),
      .rdy_i    (rdy),
      .cmd_i    (cmd_q),
      .lock_i   (lock_q),
      .ferr_i   (ferr_q),
      .single_i (ecc_s_q),
      .multi_i  (ecc_m_q),
      .data_o   (rd_data_o)
   );

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= rdy & rdy_irq_en_i;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = rdy & rdy_irq_en_i;
      end
   endgenerate
endmodule

// File: rtl/fstat_reg_chk.sv
module fstat_reg_chk
   import fstat_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_HALVES = 2,
   parameter bit IRQ_REG    = 1'b0
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  sts_rd,
   input logic                  cmd_wr_i,
   input logic                  prog_start_i,
   input logic                  busy_i,
   input logic                  irq_o,
   input logic                  cmd_err_evt_i,
   input logic                  lock_err_evt_i,
   input logic                  verify_fail_evt_i,
   input logic [NUM_HALVES-1:0] ecc_single_evt_i,
   input logic [NUM_HALVES-1:0] ecc_multi_evt_i,
   input logic                  cmd_q,
   input logic                  lock_q,
   input logic                  ferr_q,
   input logic [NUM_HALVES-1:0] ecc_s_q,
   input logic [NUM_HALVES-1:0] ecc_m_q,
   input logic [DATA_W-1:0]     rd_data_o
);
   logic [DATA_W-1:0] used_m;

   always_comb begin
      used_m = '0;
      for (int b = 0; b <= FLAG_FERR; b++) used_m[b] = 1'b1;
      for (int b = ECC_BASE; b < ECC_BASE + ECC_KINDS * NUM_HALVES; b++) used_m[b] = 1'b1;
   end

   AST_CMD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_err_evt_i |=> cmd_q); // R3
   AST_CMD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sts_rd || cmd_wr_i) && !cmd_err_evt_i) |=> !cmd_q); // R3
   AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_err_evt_i |=> lock_q); // R4
   AST_LOCK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sts_rd || cmd_wr_i) && !lock_err_evt_i) |=> !lock_q); // R4
   AST_FERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!prog_start_i && !verify_fail_evt_i) |=> $stable(ferr_q)); // R5
   AST_FERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      verify_fail_evt_i |=> ferr_q); // R9
   AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o & ~used_m) == '0); // R8
   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sts_rd |-> rd_data_o == '0); // R11

   generate
      if (IRQ_REG) begin : g_irq_reg_chk
         AST_IRQ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(irq_o) |-> $past(!busy_i)); // R2
      end else begin : g_irq_comb_chk
         AST_IRQ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o |-> !busy_i); // R2
      end
      for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_chk
         AST_ECC_SGL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ecc_single_evt_i[h] |=> ecc_s_q[h]); // R6 R7
         AST_ECC_MUL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ecc_multi_evt_i[h] |=> ecc_m_q[h]); // R6 R7
         AST_ECC_SGL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sts_rd && !ecc_single_evt_i[h]) |=> !ecc_s_q[h]); // R6 R7
         AST_ECC_MUL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sts_rd && !ecc_multi_evt_i[h]) |=> !ecc_m_q[h]); // R6 R7
         AST_ECC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!sts_rd && !ecc_single_evt_i[h]) |=> $stable(ecc_s_q[h])); // R11
      end
   endgenerate
endmodule

bind fstat_reg fstat_reg_chk #(
   .DATA_W     (DATA_W),
   .NUM_HALVES (NUM_HALVES),
   .IRQ_REG    (IRQ_REG)
) u_chk (
   .clk_i             (clk_i),
   .rst_ni            (rst_ni),
   .sts_rd            (sts_rd),
   .cmd_wr_i          (cmd_wr_i),
   .prog_start_i      (prog_start_i),
   .busy_i            (busy_i),
   .irq_o             (irq_o),
   .cmd_err_evt_i     (cmd_err_evt_i),
   .lock_err_evt_i    (lock_err_evt_i),
   .verify_fail_evt_i (verify_fail_evt_i),
   .ecc_single_evt_i  (ecc_single_evt_i),
   .ecc_multi_evt_i   (ecc_multi_evt_i),
   .cmd_q             (cmd_q),
   .lock_q            (lock_q),
   .ferr_q            (ferr_q),
   .ecc_s_q           (ecc_s_q),
   .ecc_m_q           (ecc_m_q),
   .rd_data_o         (rd_data_o)
);

// File: tb/sim_fstat_reg.sv
module sim_fstat_reg;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        rd_en_i = 1'b0;
   logic [7:0]  rd_addr_i = 8'h00;
   logic [31:0] rd_data_o;
   logic        cmd_wr_i = 1'b0;
   logic        prog_start_i = 1'b0;
   logic        busy_i = 1'b0;
   logic        rdy_irq_en_i = 1'b0;
   logic        cmd_err_evt_i = 1'b0;
   logic        lock_err_evt_i = 1'b0;
   logic        verify_fail_evt_i = 1'b0;
   logic [1:0]  ecc_single_evt_i = 2'b00;
   logic [1:0]  ecc_multi_evt_i = 2'b00;
   logic        irq_o;

   int checks = 0;
   int failures = 0;

   always #5 clk_i = ~clk_i;

   fstat_reg u0 (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .rd_en_i (rd_en_i), .rd_addr_i (rd_addr_i), .rd_data_o (rd_data_o),
      .cmd_wr_i (cmd_wr_i), .prog_start_i (prog_start_i),
      .busy_i (busy_i), .rdy_irq_en_i (rdy_irq_en_i),
      .cmd_err_evt_i (cmd_err_evt_i), .lock_err_evt_i (lock_err_evt_i),
      .verify_fail_evt_i (verify_fail_evt_i),
      .ecc_single_evt_i (ecc_single_evt_i), .ecc_multi_evt_i (ecc_multi_evt_i),
      .irq_o (irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
      end
   endtask

   // one-cycle status read: data sampled before the clearing edge
   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk_i);
      rd_en_i = 1'b1; rd_addr_i = a;
      #1 d = rd_data_o;
      @(negedge clk_i);
      rd_en_i = 1'b0;
   endtask

   task automatic pulse_all_low;
      cmd_err_evt_i = 0; lock_err_evt_i = 0; verify_fail_evt_i = 0;
      ecc_single_evt_i = 0; ecc_multi_evt_i = 0; cmd_wr_i = 0; prog_start_i = 0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      #1 chk("R10 irq after reset", {31'b0, irq_o}, 32'h0);
      rd(8'h08, d); chk("R10 reset word", d, 32'h1);
   endtask

   task automatic t_ready_irq;
      logic [31:0] d;
      @(negedge clk_i); busy_i = 1; rdy_irq_en_i = 1;
      #1 chk("R2 busy masks irq", {31'b0, irq_o}, 32'h0);
      rd(8'h08, d); chk("R1 busy word", d, 32'h0);
      @(negedge clk_i); busy_i = 0;
      #1 chk("R2 ready and enabled", {31'b0, irq_o}, 32'h1);
      @(negedge clk_i); rdy_irq_en_i = 0;
      #1 chk("R2 disabled", {31'b0, irq_o}, 32'h0);
      rd(8'h08, d); chk("R1 ready word", d, 32'h1);
   endtask

   task automatic t_cmd_lock;
      logic [31:0] d;
      @(negedge clk_i); cmd_err_evt_i = 1;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R3 cmd set", d, 32'h3);
      rd(8'h08, d); chk("R3 cmd cleared by read", d, 32'h1);
      @(negedge clk_i); cmd_err_evt_i = 1; lock_err_evt_i = 1;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R4 lock and cmd set", d, 32'h7);
      rd(8'h08, d); chk("R4 lock cleared by read", d, 32'h1);
      @(negedge clk_i); lock_err_evt_i = 1; cmd_err_evt_i = 1;
      @(negedge clk_i); pulse_all_low(); cmd_wr_i = 1;
      @(negedge clk_i); cmd_wr_i = 0;
      rd(8'h08, d); chk("R3 R4 cleared by command write", d, 32'h1);
   endtask

   task automatic t_ferr;
      logic [31:0] d;
      @(negedge clk_i); verify_fail_evt_i = 1;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R5 ferr set", d, 32'h9);
      rd(8'h08, d); chk("R5 ferr survives read", d, 32'h9);
      @(negedge clk_i); cmd_wr_i = 1;
      @(negedge clk_i); cmd_wr_i = 0;
      rd(8'h08, d); chk("R5 ferr survives command write", d, 32'h9);
      @(negedge clk_i); prog_start_i = 1;
      @(negedge clk_i); prog_start_i = 0;
      rd(8'h08, d); chk("R5 ferr cleared by program start", d, 32'h1);
   endtask

   task automatic t_ecc;
      logic [31:0] d;
      @(negedge clk_i); ecc_single_evt_i = 2'b01;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R6 low single bit16", d, 32'h0001_0001);
      rd(8'h08, d); chk("R6 cleared by read", d, 32'h1);
      @(negedge clk_i); ecc_multi_evt_i = 2'b01;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R6 low multi bit17", d, 32'h0002_0001);
      @(negedge clk_i); ecc_single_evt_i = 2'b10;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R7 high single bit18", d, 32'h0004_0001);
      @(negedge clk_i); ecc_multi_evt_i = 2'b10;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R7 high multi bit19", d, 32'h0008_0001);
      rd(8'h08, d); chk("R7 cleared by read", d, 32'h1);
      @(negedge clk_i);
      ecc_single_evt_i = 2'b11; ecc_multi_evt_i = 2'b11;
      cmd_err_evt_i = 1; lock_err_evt_i = 1; verify_fail_evt_i = 1;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R8 all flags, reserved zero", d, 32'h000F_000F);
      @(negedge clk_i); prog_start_i = 1;
      @(negedge clk_i); prog_start_i = 0;
   endtask

   task automatic t_collide;
      logic [31:0] d;
      rd(8'h08, d); chk("R9 clean start", d, 32'h1);
      @(negedge clk_i);
      rd_en_i = 1; rd_addr_i = 8'h08; cmd_err_evt_i = 1; ecc_multi_evt_i = 2'b10;
      #1 d = rd_data_o;
      chk("R9 read returns pre-clear value", d, 32'h1);
      @(negedge clk_i); rd_en_i = 0; pulse_all_low();
      rd(8'h08, d); chk("R9 event beats read clear", d, 32'h0008_0003);
      @(negedge clk_i); lock_err_evt_i = 1; cmd_wr_i = 1;
      verify_fail_evt_i = 1; prog_start_i = 1;
      @(negedge clk_i); pulse_all_low();
      rd(8'h08, d); chk("R9 event beats write and start clear", d, 32'h0000_000D);
      @(negedge clk_i); prog_start_i = 1;
      @(negedge clk_i); prog_start_i = 0;
   endtask

   task automatic t_other_addr;
      logic [31:0] d;
      @(negedge clk_i); cmd_err_evt_i = 1; ecc_single_evt_i = 2'b01;
      @(negedge clk_i); pulse_all_low();
      rd(8'h04, d); chk("R11 foreign address reads zero", d, 32'h0);
      #1 chk("R11 no read gives zero", rd_data_o, 32'h0);
      rd(8'h08, d); chk("R11 foreign read cleared nothing", d, 32'h0001_0003);
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      t_reset();
      t_ready_irq();
      t_cmd_lock();
      t_ferr();
      t_ecc();
      t_collide();
      t_other_addr();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule